// File: doc/BRIEF.md
# Machine-Cycle Clock Divide Selector

This block turns a free-running oscillator clock into a one-cycle-wide machine-cycle enable tick. The tick spacing is chosen by a 2-bit divide code together with a fast-mode bit. The fast-mode bit only matters when the divide code is `00`. In that case it selects between one tick per oscillator clock and one tick every two clocks. Software changes these settings through single-cycle write strobes. The currently selected settings are always visible on readback outputs.

Entering the one-clock rate is protected. A fixed series of control writes must come first. The series must be made while the block sits at the divide-by-4 code and the ring-oscillator flag is low. The series is: clear the multiplier enable, then set the fast-mode bit. Only after that, and only with the multiplier reporting ready, is a write of code `00` accepted. Unrelated cycles may fall between the steps. A control write that breaks the series sends it back to its start. Leaving the one-clock rate needs nothing more than a plain write.

When the automatic switchback is enabled and serial activity is reported while the slow rate is selected, the block moves itself to divide-by-4. New rates always start at a tick boundary, so no machine cycle is cut short.

Top module: `mcycle_divsel`

## Requirements
- R1: While reset is held, and after it is released, the divide code reads `10` and the fast bit reads 0. The tick then repeats every 4 clocks.
- R2: The tick spacing in oscillator clocks is set by the settings:
  - code `00` with fast bit 1: 1 clock;
  - code `00` with fast bit 0: 2 clocks;
  - code `10`: 4 clocks, for either value of the fast bit;
  - code `11`: SLOW_RATIO clocks (1024 by default), for either value of the fast bit.
- R3: A write of the reserved code `01` leaves the divide code unchanged. The code `01` never appears on the readback.
- R4: The one-clock rate is entered by this series, with any number of cycles without writes between the steps:
  1. a multiplier-enable write of 0 while the code is `10` and the ring flag is 0;
  2. a fast-bit write of 1 under the same conditions;
  3. a divide write of `00` while `mul_ready` is 1.
- R5: A divide write of `00` while the fast bit is 1 is ignored in any of these cases:
  - the series of R4 is incomplete;
  - the series was broken by an out-of-order control write, meaning any write other than the expected next step (a multiplier-enable write of 1, a step made with the ring flag high, or a fast-bit write that does not follow a step 1);
  - `mul_ready` is 0.
  Every divide write returns the series to its start.
- R6: A fast-bit write while the code is `00` leaves the fast bit unchanged.
- R7: Divide writes of `10` or `11` are always accepted, including from the one-clock rate.
- R8: When `swb_en` and `ser_act` are both 1 while the code is `11`, the code becomes `10` on the next clock. With `swb_en` at 0, the code stays `11`.
- R9: A setting change takes effect from the next tick onward. The machine cycle in progress completes at its old length.
- R10: When strobes coincide, the divide write wins over the fast-bit write, which wins over the multiplier-enable write. The losing writes have no effect.
- R11: A divide write of `00` while the fast bit is 0 is accepted without any series, giving the 2-clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Divide code write strobe |
| div_wd | input | 2 | Divide code write data |
| fast_we | input | 1 | Fast-mode bit write strobe |
| fast_wd | input | 1 | Fast-mode bit write data |
| mulen_we | input | 1 | Multiplier enable write strobe |
| mulen_wd | input | 1 | Multiplier enable write data |
| ring_active | input | 1 | Ring-oscillator flag; must be 0 during the entry series |
| mul_ready | input | 1 | Frequency multiplier ready |
| swb_en | input | 1 | Automatic switchback enable |
| ser_act | input | 1 | Serial activity seen |
| mc_tick | output | 1 | Machine-cycle enable tick |
| div_rd | output | 2 | Current divide code |
| fast_rd | output | 1 | Current fast-mode bit |

## Verification
Every reachable setting pair (`00` with fast bit 0 and with fast bit 1, `10`, and `11`) is measured by counting clocks between consecutive ticks. This separates the four rates and shows that the fast bit is ignored outside code `00`.

The entry series is tried in several forms:
- completed in order with idle cycles between the steps, which is the only form that must succeed;
- started without the enable step;
- with the ring flag high;
- with the multiplier not ready;
- broken by a stray enable write of 1.

Each failing form tells a sequence-tracking fault apart from a condition-checking fault.

A write placed one cycle after a tick shows whether the period in progress keeps its old length. The switchback is tried with its enable off and on, and coincident strobes expose the write priority.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  localparam logic [1:0] DIV_HALF = 2'b00;
  localparam logic [1:0] DIV_RSV  = 2'b01;
  localparam logic [1:0] DIV_QUAD = 2'b10;
  localparam logic [1:0] DIV_SLOW = 2'b11;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CLR  = 2'd1,
    SEQ_ARM  = 2'd2
  } seq_e;

endpackage

// File: rtl/mcd_rst_sync.sv
module mcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mcd_ctrl.sv
module mcd_ctrl
  import mcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       div_we,
  input  logic [1:0] div_wd,
  input  logic       fast_we,
  input  logic       fast_wd,
  input  logic       mulen_we,
  input  logic       mulen_wd,
  input  logic       ring_active,
  input  logic       mul_ready,
  input  logic       swb_en,
  input  logic       ser_act,
  output logic [1:0] div_q,
  output logic       fast_q
);

  seq_e       seq_q, seq_n;
  logic [1:0] div_n;
  logic       fast_n;
  logic       quad_ok;
  logic       swb_hit;
  logic       upd_en;

  assign quad_ok = (div_q == DIV_QUAD) && !ring_active;
  assign swb_hit = swb_en && ser_act && (div_q == DIV_SLOW) && !div_we;
  assign upd_en  = div_we || fast_we || mulen_we || swb_hit;

  always_comb begin
    div_n  = div_q;
    fast_n = fast_q;
    seq_n  = seq_q;
    if (div_we) begin
      seq_n = SEQ_IDLE;
      unique case (div_wd)
        DIV_HALF: if (!fast_q || (seq_q == SEQ_ARM && mul_ready)) div_n = DIV_HALF;
        DIV_QUAD: div_n = DIV_QUAD;
        DIV_SLOW: div_n = DIV_SLOW;
        default:  div_n = div_q;
      endcase
    end else if (fast_we) begin
      seq_n = (fast_wd && seq_q == SEQ_CLR && quad_ok) ? SEQ_ARM : SEQ_IDLE;
      if (div_q != DIV_HALF) fast_n = fast_wd;
    end else if (mulen_we) begin
      seq_n = (!mulen_wd && quad_ok) ? SEQ_CLR : SEQ_IDLE;
    end
    if (swb_hit) div_n = DIV_QUAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_QUAD;
      fast_q <= 1'b0;
      seq_q  <= SEQ_IDLE;
    end else if (upd_en) begin
      div_q  <= div_n;
      fast_q <= fast_n;
      seq_q  <= seq_n;
    end
  end

endmodule

// File: rtl/mcd_tick.sv
module mcd_tick
  import mcd_pkg::*;
#(
  parameter int SLOW_RATIO = 1024,
  parameter int QUAD_RATIO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_q,
  input  logic       fast_q,
  output logic       tick
);

  localparam int CNT_W = $clog2(SLOW_RATIO);

  logic [CNT_W-1:0] cnt_q, cnt_n, reload;

  always_comb begin
    unique case (div_q)
      DIV_HALF: reload = fast_q ? '0 : CNT_W'(1);
      DIV_SLOW: reload = CNT_W'(SLOW_RATIO - 1);
      default:  reload = CNT_W'(QUAD_RATIO - 1);
    endcase
  end

  assign tick  = (cnt_q == '0);
  assign cnt_n = tick ? reload : cnt_q - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(QUAD_RATIO - 1);
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/mcycle_divsel.sv
module mcycle_divsel #(
  parameter int SLOW_RATIO = 1024,
  parameter int QUAD_RATIO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       div_we,
  input  logic [1:0] div_wd,
  input  logic       fast_we,
  input  logic       fast_wd,
  input  logic       mulen_we,
  input  logic       mulen_wd,
  input  logic       ring_active,
  input  logic       mul_ready,
  input  logic       swb_en,
  input  logic       ser_act,
  output logic       mc_tick,
  output logic [1:0] div_rd,
  output logic       fast_rd
);

  logic rst_n_int;

  mcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mcd_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .div_we      (div_we),
    .div_wd      (div_wd),
    .fast_we     (fast_we),
    .fast_wd     (fast_wd),
    .mulen_we    (mulen_we),
    .mulen_wd    (mulen_wd),
    .ring_active (ring_active),
    .mul_ready   (mul_ready),
    .swb_en      (swb_en),
    .ser_act     (ser_act),
    .div_q       (div_rd),
    .fast_q      (fast_rd)
  );

  mcd_tick #(.SLOW_RATIO(SLOW_RATIO), .QUAD_RATIO(QUAD_RATIO)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .div_q  (div_rd),
    .fast_q (fast_rd),
    .tick   (mc_tick)
  );

endmodule

// File: rtl/mcycle_divsel_chk.sv
module mcycle_divsel_chk
  import mcd_pkg::*;
#(
  parameter int SLOW_RATIO = 1024,
  parameter int QUAD_RATIO = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       div_we,
  input logic [1:0] div_wd,
  input logic       mul_ready,
  input logic       swb_en,
  input logic       ser_act,
  input logic       mc_tick,
  input logic [1:0] div_rd,
  input logic       fast_rd
);

  localparam int GW = $clog2(SLOW_RATIO) + 1;

  function automatic logic [GW-1:0] ratio_of(input logic [1:0] d, input logic f);
    if (d == DIV_HALF)      ratio_of = f ? GW'(1) : GW'(2);
    else if (d == DIV_SLOW) ratio_of = GW'(SLOW_RATIO);
    else                    ratio_of = GW'(QUAD_RATIO);
  endfunction

  logic [GW-1:0] gap_q, exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GW'(1);
      exp_q <= GW'(QUAD_RATIO);
    end else if (mc_tick) begin
      gap_q <= GW'(1);
      exp_q <= ratio_of(div_rd, fast_rd);
    end else begin
      gap_q <= gap_q + GW'(1);
    end
  end

  // R2 R9: spacing equals the rate in force at the previous tick
  a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mc_tick |-> gap_q == exp_q);

  a_r3_no_rsv_code: assert property (@(posedge clk) disable iff (!rst_n)
    div_rd != DIV_RSV);

  a_r3_rsv_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (div_we && div_wd == DIV_RSV) |=> $stable(div_rd));

  a_r5_entry_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rd == DIV_HALF && fast_rd && !$past(div_rd == DIV_HALF && fast_rd))
      |-> $past(div_we && div_wd == DIV_HALF && mul_ready));

  a_r6_fast_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rd == DIV_HALF) |=> $stable(fast_rd));

  a_r8_switchback: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_en && ser_act && div_rd == DIV_SLOW && !div_we) |=> div_rd == DIV_QUAD);

endmodule

bind mcycle_divsel mcycle_divsel_chk #(
  .SLOW_RATIO(SLOW_RATIO),
  .QUAD_RATIO(QUAD_RATIO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .div_we    (div_we),
  .div_wd    (div_wd),
  .mul_ready (mul_ready),
  .swb_en    (swb_en),
  .ser_act   (ser_act),
  .mc_tick   (mc_tick),
  .div_rd    (div_rd),
  .fast_rd   (fast_rd)
);

// File: tb/mcycle_divsel_test.sv
`timescale 1ns/1ps
module mcycle_divsel_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_we, fast_we, fast_wd, mulen_we, mulen_wd;
  logic [1:0] div_wd;
  logic       ring_active, mul_ready, swb_en, ser_act;
  logic       mc_tick, fast_rd;
  logic [1:0] div_rd;
  int         errors = 0;
  int         checks = 0;
  int         n;

  always #2 clk = ~clk;

  mcycle_divsel uut (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wd(div_wd),
    .fast_we(fast_we), .fast_wd(fast_wd), .mulen_we(mulen_we), .mulen_wd(mulen_wd),
    .ring_active(ring_active), .mul_ready(mul_ready), .swb_en(swb_en),
    .ser_act(ser_act), .mc_tick(mc_tick), .div_rd(div_rd), .fast_rd(fast_rd)
  );

  function automatic int exp_per(input logic [1:0] d, input logic f);
    if (d == 2'b00)      return f ? 1 : 2;
    else if (d == 2'b11) return 1024;
    else                 return 4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    while (!mc_tick) @(negedge clk);
  endtask

  // measures two consecutive periods and returns the second
  task automatic period(output int p);
    for (int k = 0; k < 2; k++) begin
      wait_tick();
      p = 0;
      do begin @(negedge clk); p++; end while (!mc_tick);
    end
  endtask

  task automatic wr_div(input logic [1:0] c);
    div_we = 1'b1; div_wd = c; @(negedge clk); div_we = 1'b0;
  endtask

  task automatic wr_fast(input logic v);
    fast_we = 1'b1; fast_wd = v; @(negedge clk); fast_we = 1'b0;
  endtask

  task automatic wr_mulen(input logic v);
    mulen_we = 1'b1; mulen_wd = v; @(negedge clk); mulen_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; div_we = 0; div_wd = 0; fast_we = 0; fast_wd = 0;
    mulen_we = 0; mulen_wd = 0; ring_active = 0; mul_ready = 0; swb_en = 0; ser_act = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset code", div_rd, 2);
    chk("R1 reset fast", fast_rd, 0);
    chk("R1 no tick in reset", mc_tick, 0);
    rst_n = 1'b1;
    period(n); chk("R1 reset period", n, 4);

    // R9: write one cycle after a tick, current cycle keeps old length
    wait_tick(); @(negedge clk);
    wr_div(2'b11);
    n = 1; while (!mc_tick) begin @(negedge clk); n++; end
    chk("R9 old period completes", n + 1, 4);
    chk("R7 code 11 accepted", div_rd, 3);
    period(n); chk("R2 slow period", n, exp_per(2'b11, 1'b0));

    wr_div(2'b01);
    chk("R3 reserved ignored", div_rd, 3);

    ser_act = 1; @(negedge clk); ser_act = 0;
    chk("R8 no switchback when disabled", div_rd, 3);
    swb_en = 1; ser_act = 1; @(negedge clk); ser_act = 0; swb_en = 0;
    chk("R8 switchback to 10", div_rd, 2);
    period(n); chk("R8 period after switchback", n, 4);

    wr_div(2'b00);
    chk("R11 code 00 without series", div_rd, 0);
    period(n); chk("R11 half period", n, exp_per(2'b00, 1'b0));
    wr_fast(1'b1);
    chk("R6 fast write ignored at 00", fast_rd, 0);
    period(n); chk("R6 period unchanged", n, 2);

    wr_div(2'b10);
    wr_fast(1'b1);
    chk("R5 fast bit stored out of order", fast_rd, 1);
    mul_ready = 1;
    wr_div(2'b00);
    chk("R5 entry without enable step", div_rd, 2);
    period(n); chk("R2 fast bit ignored at 10", n, exp_per(2'b10, 1'b1));

    ring_active = 1; wr_mulen(1'b0); ring_active = 0;
    wr_fast(1'b1); wr_div(2'b00);
    chk("R5 entry with ring flag high", div_rd, 2);

    wr_mulen(1'b0); repeat (3) @(negedge clk);
    wr_fast(1'b1); repeat (2) @(negedge clk);
    mul_ready = 0; wr_div(2'b00);
    chk("R5 entry without ready", div_rd, 2);

    mul_ready = 1;
    wr_mulen(1'b0); wr_mulen(1'b1); wr_fast(1'b1); wr_div(2'b00);
    chk("R5 entry after broken series", div_rd, 2);

    // R10 priority: divide beats fast-bit write
    wr_fast(1'b0);
    chk("R10 fast cleared", fast_rd, 0);
    div_we = 1; div_wd = 2'b11; fast_we = 1; fast_wd = 1;
    @(negedge clk); div_we = 0; fast_we = 0;
    chk("R10 divide write applied", div_rd, 3);
    chk("R10 fast write dropped", fast_rd, 0);
    wr_div(2'b10);

    // R4 full series with idle gaps
    wr_mulen(1'b0); repeat (2) @(negedge clk);
    wr_fast(1'b1); repeat (2) @(negedge clk);
    wr_div(2'b00);
    chk("R4 entry code", div_rd, 0);
    chk("R4 entry fast", fast_rd, 1);
    period(n); chk("R4 one-clock period", n, exp_per(2'b00, 1'b1));

    wr_div(2'b11);
    chk("R7 leave fast mode", div_rd, 3);
    period(n); chk("R2 slow with fast bit", n, exp_per(2'b11, 1'b1));
    wr_div(2'b10);
    period(n); chk("R7 back to quad", n, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule